// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Binary Counter

This block is a chain of 4-bit synchronous binary counter stages. Every stage counts up or down under one shared direction pin and one enable. It is built from toggle-style next-state logic: each bit flips or holds on the common clock edge, depending on the bits below it. Each stage produces two carry outputs. One is a carry for counting up and the other is a borrow for counting down. Both are qualified by the direction and by that stage's enable, so that a following stage can be enabled from them.

The top module chains a parameterised number of these stages into one wider counter. The first stage takes the external enable. Each later stage is enabled by the OR of the two carry outputs of the stage before it. All stages share the clock, the synchronous reset and the direction pin, so no flip-flop is ever clocked by another flip-flop's output. The carry outputs of the last stage go to the ports, so a further chain can be enabled from them. The pins are plain control and status pins: no data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `tgc_chain`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes all zeros on that edge, whatever `en` and `up` are.
- R2: When `en` is low, `count` holds its value across the edge, and `carry_up` and `carry_dn` are both 0.
- R3: When `en` is high, bit 0 of `count` inverts on every rising edge, in either direction.
- R4: With `en` high and `up` = 1 (up), a bit inverts only when every bit below it is 1, so the count increases by one per edge.
- R5: With `en` high and `up` = 0 (down), a bit inverts only when every bit below it is 0, so the count decreases by one per edge. For example, the low nibble 0100 is followed by 0011.
- R6: Counting up wraps from all ones to all zeros, and counting down wraps from all zeros to all ones.
- R7: `carry_up` is 1 exactly when `count` is all ones, `up` = 1 and `en` = 1.
- R8: `carry_dn` is 1 exactly when `count` is all zeros, `up` = 0 and `en` = 1.
- R9: A stage advances only when the OR of the previous stage's two carries is 1. The whole chain therefore behaves as a single STAGES×4-bit counter, including at the nibble boundaries (0x0F↔0x10).
- R10: A change of `up` takes effect on the next edge, with no lost or repeated count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; all flip-flops update on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the count |
| en | input | 1 | Count enable for the first stage |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | STAGES*STAGE_W | Concatenated count; stage 0 is the least significant nibble |
| carry_up | output | 1 | Up-carry of the last stage (all ones, counting up, enabled) |
| carry_dn | output | 1 | Down-borrow of the last stage (all zeros, counting down, enabled) |

## Verification
Some behaviours are checked by the assertions on every cycle: the increment or decrement by exactly one, the bit-0 inversion, holding when disabled, the clearing by reset, and the exact conditions for each carry. These are checked over the full counter width, so the per-stage enable chaining is covered implicitly. Some behaviours can only be shown by the bench's scenarios: the specific wrap points in both directions, the crossings of the nibble boundary in each direction, and a reversal of direction landing on the right value. The bench also shows that reset wins over an active enable, and it runs one complete up-counting lap through all 256 values.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef struct packed {
    logic cy_up;
    logic cy_dn;
  } carry_t;
endpackage

// File: rtl/tgc_toggle_mask.sv
// Per-bit toggle decision: a bit flips when every lower bit matches the
// direction's trigger value (ones going up, zeros going down).
module tgc_toggle_mask #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  tgc_pkg::dir_e dir,
  input  logic         en,
  output logic [W-1:0] tmask,
  output logic         all_ones,
  output logic         all_zeros
);
  logic [W:0] ones_below;
  logic [W:0] zeros_below;

  assign ones_below[0]  = 1'b1;
  assign zeros_below[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign ones_below[i+1]  = ones_below[i] & q[i];
    assign zeros_below[i+1] = zeros_below[i] & ~q[i];
    assign tmask[i] = en & ((dir == tgc_pkg::DIR_UP) ? ones_below[i] : zeros_below[i]);
  end

  assign all_ones  = ones_below[W];
  assign all_zeros = zeros_below[W];
endmodule

// File: rtl/tgc_stage.sv
// One counter stage: toggle register plus qualified carries.
module tgc_stage #(
  parameter int W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  tgc_pkg::dir_e dir,
  output logic [W-1:0]  q,
  output tgc_pkg::carry_t cy
);
  logic [W-1:0] tmask;
  logic         all_ones;
  logic         all_zeros;

  tgc_toggle_mask #(.W(W)) u_mask (
    .q        (q),
    .dir      (dir),
    .en       (en),
    .tmask    (tmask),
    .all_ones (all_ones),
    .all_zeros(all_zeros)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q ^ tmask;
  end

  always_comb begin
    cy.cy_up = en & all_ones  & (dir == tgc_pkg::DIR_UP);
    cy.cy_dn = en & all_zeros & (dir == tgc_pkg::DIR_DOWN);
  end
endmodule

// File: rtl/tgc_chain.sv
// Chain of synchronous up/down stages sharing clock, reset and direction.
module tgc_chain #(
  parameter int STAGES  = 2,
  parameter int STAGE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        up,
  output logic [STAGES*STAGE_W-1:0]   count,
  output logic                        carry_up,
  output logic                        carry_dn
);
  localparam int TOTAL_W = STAGES * STAGE_W;

  tgc_pkg::dir_e   dir;
  logic            stage_en [STAGES+1];
  tgc_pkg::carry_t stage_cy [STAGES];

  assign dir         = tgc_pkg::dir_e'(up);
  assign stage_en[0] = en;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    tgc_stage #(.W(STAGE_W)) u_stage (
      .clk(clk),
      .rst(rst),
      .en (stage_en[k]),
      .dir(dir),
      .q  (count[k*STAGE_W +: STAGE_W]),
      .cy (stage_cy[k])
    );
    assign stage_en[k+1] = stage_cy[k].cy_up | stage_cy[k].cy_dn;
  end

  assign carry_up = stage_cy[STAGES-1].cy_up;
  assign carry_dn = stage_cy[STAGES-1].cy_dn;

  logic unused_tail;
  assign unused_tail = stage_en[STAGES] & (TOTAL_W > 0);
endmodule

// File: rtl/tgc_chain_chk.sv
module tgc_chain_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          up,
  input logic [CW-1:0] count,
  input logic          carry_up,
  input logic          carry_dn
);
  localparam logic [CW-1:0] ONE = CW'(1);

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> count == '0);
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> count == $past(count));
  p_carries_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!carry_up && !carry_dn));
  p_lsb_flips_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> count[0] != $past(count[0]));
  p_increment_r4: assert property (@(posedge clk) disable iff (rst)
    (en && up) |=> count == $past(count) + ONE);
  p_decrement_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !up) |=> count == $past(count) - ONE);
  p_carry_up_cause_r7: assert property (@(posedge clk) disable iff (rst)
    carry_up |-> (&count && up && en));
  p_carry_up_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (&count && up && en) |-> carry_up);
  p_carry_dn_cause_r8: assert property (@(posedge clk) disable iff (rst)
    carry_dn |-> (count == '0 && !up && en));
  p_carry_dn_fires_r8: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !up && en) |-> carry_dn);
endmodule

bind tgc_chain tgc_chain_chk #(.CW(STAGES*STAGE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .up      (up),
  .count   (count),
  .carry_up(carry_up),
  .carry_dn(carry_dn)
);

// File: tb/sim_tgc_chain.sv
`timescale 1ns/1ps
module sim_tgc_chain;
  localparam int STAGES = 2;
  localparam int SW     = 4;
  localparam int CW     = STAGES * SW;
  localparam real HALF  = 2.0;
  localparam int NVEC   = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic up  = 1'b0;
  logic [CW-1:0] count;
  logic carry_up, carry_dn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  tgc_chain #(.STAGES(STAGES), .STAGE_W(SW)) u0 (
    .clk(clk), .rst(rst), .en(en), .up(up),
    .count(count), .carry_up(carry_up), .carry_dn(carry_dn)
  );

  // {rst, en, up, exp carry_up before edge, exp carry_dn before edge, exp count after edge}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0,1'b1,1'b0, 1'b0,1'b1, 8'hFF},  // R6 R8 down wrap
    {1'b0,1'b1,1'b1, 1'b1,1'b0, 8'h00},  // R6 R7 up wrap
    {1'b0,1'b1,1'b1, 1'b0,1'b0, 8'h01},  // R3 R4
    {1'b0,1'b0,1'b1, 1'b0,1'b0, 8'h01},  // R2
    {1'b0,1'b0,1'b0, 1'b0,1'b0, 8'h01},  // R2
    {1'b0,1'b1,1'b0, 1'b0,1'b0, 8'h00},  // R5 R10
    {1'b0,1'b1,1'b0, 1'b0,1'b1, 8'hFF},  // R6 R8
    {1'b0,1'b1,1'b0, 1'b0,1'b0, 8'hFE},  // R5
    {1'b0,1'b1,1'b1, 1'b0,1'b0, 8'hFF},  // R10
    {1'b0,1'b0,1'b1, 1'b0,1'b0, 8'hFF},  // R2 carry gated
    {1'b0,1'b1,1'b1, 1'b1,1'b0, 8'h00},  // R7 R6
    {1'b0,1'b1,1'b1, 1'b0,1'b0, 8'h01},  // R4
    {1'b0,1'b1,1'b1, 1'b0,1'b0, 8'h02},  // R4
    {1'b1,1'b1,1'b1, 1'b0,1'b0, 8'h00}   // R1 reset wins
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // drive after the falling edge, run one rising edge, come back to the falling edge
  task automatic step(input logic r, input logic e, input logic u);
    rst = r; en = e; up = u;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [CW-1:0] exp;
    do_reset();
    check("R1 reset state", int'(count), 0);
    check("R1 reset carries", int'({carry_up, carry_dn}), 0);

    for (int i = 0; i < NVEC; i++) begin
      rst = VEC[i][12]; en = VEC[i][11]; up = VEC[i][10];
      #0.5;
      check($sformatf("vec%0d R7 carry_up", i), int'(carry_up), int'(VEC[i][9]));
      check($sformatf("vec%0d R8 carry_dn", i), int'(carry_dn), int'(VEC[i][8]));
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vec%0d count", i), int'(count), int'(VEC[i][7:0]));
    end
    rst = 1'b0;

    // R4 R6 R9: a complete up lap
    do_reset();
    exp = '0;
    for (int i = 0; i < 256; i++) begin
      step(1'b0, 1'b1, 1'b1);
      exp = exp + 1'b1;
      check("R4 R9 up lap", int'(count), int'(exp));
    end

    // R5: 0x04 -> 0x03 (low nibble 0100 -> 0011)
    do_reset();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
    check("R5 setup 0x04", int'(count), 8'h04);
    step(1'b0, 1'b1, 1'b0);
    check("R5 0100->0011", int'(count), 8'h03);

    // R9: nibble boundary both ways
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b1);
    check("R9 setup 0x0F", int'(count), 8'h0F);
    step(1'b0, 1'b1, 1'b1);
    check("R9 0x0F->0x10", int'(count), 8'h10);
    step(1'b0, 1'b1, 1'b0);
    check("R9 0x10->0x0F", int'(count), 8'h0F);

    // R5 R9: upper nibble 0100 -> 0011 through the cascade
    for (int i = 0; i < 49; i++) step(1'b0, 1'b1, 1'b1);
    check("R5 setup 0x40", int'(count), 8'h40);
    step(1'b0, 1'b1, 1'b0);
    check("R5 R9 0x40->0x3F", int'(count), 8'h3F);

    // R2: long hold with direction toggling
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b0, i[0]);
      check("R2 hold", int'(count), 8'h3F);
    end

    // R1: reset mid-count while enabled downward
    step(1'b1, 1'b1, 1'b0);
    check("R1 reset mid-count", int'(count), 0);

    summary();
  end
endmodule